// File: doc/BRIEF.md
# Double-Latched Programmable Down Divider

This block divides an already prescaled oscillator clock by a programmable integer ratio. It is built around a 15-bit down counter. When the counter reaches zero, it emits a one-cycle output pulse and reloads. A second output toggles on every such pulse, so it runs at half the pulse rate and can be routed to a test buffer.

A new ratio may be written at any cycle, with no regard to where the counter stands. The write strobe captures the value into a capture register. The value is then passed to a hold register only on the cycle where the counter reaches zero. The counter always reloads from the hold register, so a division period that is already running never sees a half-written ratio. A ratio below the lowest legal value is raised to that value when it is captured. The reset input is expected to be already released in step with the clock.

Top module: `prog_down_divider`

## Requirements
- R1: While reset is low and after it, until a ratio is written, both ratio registers hold 17. After reset, `div_pulse_o` and `div_half_o` are low, and the divider runs with period 17.
- R2: With a ratio N in effect, `div_pulse_o` is high for exactly one clock cycle in every N cycles. It is high in the cycle whose closing edge reloads the counter.
- R3: The ratio is plain binary. `ratio_i[14]` has weight 16384 and `ratio_i[0]` has weight 1. For example, 15'h4001 gives a period of 16385 cycles.
- R4: A written value from 0 to 16 is captured as 17, giving a period of 17.
- R5: A ratio written at any cycle does not change the period in progress, and does not change the period that starts at the next pulse. It governs the period that starts at the second pulse after the write.
- R6: If several writes occur before a pulse, only the last one is passed on.
- R7: `div_half_o` inverts on the clock edge that ends every pulse cycle and is otherwise steady. Its period is therefore 2N.
- R8: The largest ratio, 32767, gives a period of 32767 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Prescaled oscillator clock being divided |
| rst_ni | input | 1 | Active-low reset, asserted asynchronously, released in step with clk_i |
| ratio_wr_i | input | 1 | One-cycle strobe capturing ratio_i |
| ratio_i | input | 15 | New division ratio, binary, MSB weight 16384 |
| div_pulse_o | output | 1 | One-cycle pulse per division period |
| div_half_o | output | 1 | Divider output divided by two |

## Verification
The bench issues writes exactly on a pulse cycle and one cycle later. A design that moved the ratio straight into the counter, or that skipped one of the two registers, would shorten or lengthen the first or second period after the write. Values 0 and 5 are written to expose a missing floor, which would give a runaway or tiny period. Two writes inside one period catch a design that keeps the first value. A long run at 16385 and 32767 exposes a truncated counter or wrong bit weights.

// File: rtl/div_pkg.sv
package div_pkg;
  localparam int unsigned DIV_RATIO_W   = 15;
  localparam int unsigned DIV_MIN_RATIO = 17;
endpackage

// File: rtl/div_ratio_capture.sv
module div_ratio_capture #(
  parameter int unsigned W   = div_pkg::DIV_RATIO_W,
  parameter int unsigned MIN = div_pkg::DIV_MIN_RATIO
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] ratio_i,
  output logic [W-1:0] ratio_o
);
  localparam logic [W-1:0] MinVal = W'(MIN);

  logic [W-1:0] cap_q, cap_d, floored;

  always_comb begin
    floored = (ratio_i < MinVal) ? MinVal : ratio_i;
    cap_d   = wr_i ? floored : cap_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cap_q <= MinVal;
    else         cap_q <= cap_d;
  end

  assign ratio_o = cap_q;
endmodule

// File: rtl/div_ratio_hold.sv
module div_ratio_hold #(
  parameter int unsigned W   = div_pkg::DIV_RATIO_W,
  parameter int unsigned MIN = div_pkg::DIV_MIN_RATIO
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] ratio_i,
  output logic [W-1:0] ratio_o
);
  localparam logic [W-1:0] MinVal = W'(MIN);

  logic [W-1:0] hold_q, hold_d;

  always_comb hold_d = load_i ? ratio_i : hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hold_q <= MinVal;
    else         hold_q <= hold_d;
  end

  assign ratio_o = hold_q;
endmodule

// File: rtl/div_down_counter.sv
module div_down_counter #(
  parameter int unsigned W   = div_pkg::DIV_RATIO_W,
  parameter int unsigned MIN = div_pkg::DIV_MIN_RATIO
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] reload_i,
  output logic         term_o,
  output logic [W-1:0] count_o
);
  localparam logic [W-1:0] StartVal = W'(MIN - 1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         term;

  always_comb begin
    term  = (cnt_q == '0);
    cnt_d = term ? (reload_i - 1'b1) : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= StartVal;
    else         cnt_q <= cnt_d;
  end

  assign term_o  = term;
  assign count_o = cnt_q;
endmodule

// File: rtl/div_toggle.sv
module div_toggle (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic q_o
);
  logic tog_q, tog_d;

  always_comb tog_d = en_i ? ~tog_q : tog_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tog_q <= 1'b0;
    else         tog_q <= tog_d;
  end

  assign q_o = tog_q;
endmodule

// File: rtl/prog_down_divider.sv
module prog_down_divider #(
  parameter int unsigned RATIO_W   = div_pkg::DIV_RATIO_W,
  parameter int unsigned MIN_RATIO = div_pkg::DIV_MIN_RATIO
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ratio_wr_i,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               div_pulse_o,
  output logic               div_half_o
);
  logic [RATIO_W-1:0] ratio_cap;
  logic [RATIO_W-1:0] ratio_hold;
  logic [RATIO_W-1:0] count;
  logic               term;

  div_ratio_capture #(.W(RATIO_W), .MIN(MIN_RATIO)) u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (ratio_wr_i),
    .ratio_i (ratio_i),
    .ratio_o (ratio_cap)
  );

  // Transfer only on the terminal cycle, in step with the divider output.
  div_ratio_hold #(.W(RATIO_W), .MIN(MIN_RATIO)) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (term),
    .ratio_i (ratio_cap),
    .ratio_o (ratio_hold)
  );

  div_down_counter #(.W(RATIO_W), .MIN(MIN_RATIO)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .reload_i (ratio_hold),
    .term_o   (term),
    .count_o  (count)
  );

  div_toggle u_half (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (term),
    .q_o    (div_half_o)
  );

  assign div_pulse_o = term;
endmodule

// File: rtl/prog_down_divider_chk.sv
module prog_down_divider_chk #(
  parameter int unsigned W   = div_pkg::DIV_RATIO_W,
  parameter int unsigned MIN = div_pkg::DIV_MIN_RATIO
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         pulse,
  input logic         half,
  input logic [W-1:0] cap,
  input logic [W-1:0] hold,
  input logic [W-1:0] count
);
  a_r2_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse |=> !pulse);

  a_r2_count_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pulse |=> count == $past(count) - 1'b1);

  a_r7_half_flips: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse |=> half != $past(half));

  a_r7_half_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pulse |=> $stable(half));

  a_r4_floor_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap >= W'(MIN));

  a_r5_hold_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pulse |=> $stable(hold));

  a_r6_hold_takes_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse |=> hold == $past(cap));
endmodule

bind prog_down_divider prog_down_divider_chk #(.W(RATIO_W), .MIN(MIN_RATIO)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .pulse  (div_pulse_o),
  .half   (div_half_o),
  .cap    (ratio_cap),
  .hold   (ratio_hold),
  .count  (count)
);

// File: tb/prog_down_divider_tb.sv
module prog_down_divider_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [14:0] ratio = '0;
  logic        pulse, half;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  // behavioural reference state
  int m_cap = 17, m_hold = 17, m_cnt = 16;
  bit m_half = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prog_down_divider u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .ratio_wr_i  (wr),
    .ratio_i     (ratio),
    .div_pulse_o (pulse),
    .div_half_o  (half)
  );

  function automatic int floor17(int v);
    return (v < 17) ? 17 : v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cap = 17; m_hold = 17; m_cnt = 16; m_half = 0;
    end else begin
      int old_cap;
      old_cap = m_cap;
      if (wr) m_cap = floor17(int'(ratio));
      if (m_cnt == 0) begin
        m_cnt  = m_hold - 1;
        m_hold = old_cap;
        m_half = !m_half;
      end else begin
        m_cnt = m_cnt - 1;
      end
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model (R2 pulse, R7 half)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(pulse == (m_cnt == 0), "R2", int'(pulse), int'(m_cnt == 0));
      check(half == m_half, "R7", int'(half), int'(m_half));
    end
  end

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, WATCHDOG);
      finish_run();
    end
  end

  // Called on a negedge where pulse is high; returns cycles to the next pulse.
  task automatic next_interval(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!pulse);
  endtask

  task automatic write_now(int v);
    wr = 1'b1; ratio = 15'(v);
  endtask

  // Write on a pulse cycle, then expect old, old, new.
  task automatic write_and_measure(int v1, int v2, bit two, int old_n, int new_n, string req);
    int n;
    bit h0;
    write_now(v1);
    h0 = half;
    @(negedge clk);
    if (two) write_now(v2); else wr = 1'b0;
    @(negedge clk);
    wr = 1'b0;
    n = 2;
    while (!pulse) begin @(negedge clk); n++; end
    check(n == old_n, "R5", n, old_n);
    check(half != h0, "R7", int'(half), int'(!h0));
    next_interval(n);
    check(n == old_n, "R5", n, old_n);
    next_interval(n);
    check(n == new_n, req, n, new_n);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check(pulse == 1'b0, "R1", int'(pulse), 0);
    check(half == 1'b0, "R1", int'(half), 0);
    rst_n = 1'b1;
    check(pulse == 1'b0, "R1", int'(pulse), 0);
    check(half == 1'b0, "R1", int'(half), 0);
    n = 0;
    do begin @(negedge clk); n++; end while (!pulse);
    check(n == 16, "R1", n, 16);
    next_interval(n);
    check(n == 17, "R1", n, 17);
    next_interval(n);
    check(n == 17, "R1", n, 17);
    // R2: plain ratio
    write_and_measure(100, 0, 0, 17, 100, "R2");
    next_interval(n);
    check(n == 100, "R2", n, 100);
    // R4: floor
    write_and_measure(5, 0, 0, 100, 17, "R4");
    // R6: two writes, last one wins; also value 0 floored
    write_and_measure(0, 40, 1, 17, 40, "R6");
    write_and_measure(23, 0, 0, 40, 23, "R4");
    // R3: bit weights
    write_and_measure(16385, 0, 0, 23, 16385, "R3");
    // R8: maximum ratio
    write_and_measure(32767, 0, 0, 16385, 32767, "R8");
    finish_run();
  end
endmodule